// File: doc/BRIEF.md
# Aging-Counter Page Victim Selector

This block keeps a short reference history for each page slot of a small memory pool and names the slot that has gone unused the longest, as an inexpensive stand-in for least-recently-used replacement. Every slot owns a sticky referenced flag and a history register. Access pulses set the flag between sampling ticks. On each tick, every history register moves one place toward its low end and takes the flag into its top bit, and then the flag is cleared. A reference made during a recent interval therefore lands in a higher bit than an older one, and outweighs every older reference combined.

A replacement request samples `victim_idx`. This output always shows the slot whose history register holds the smallest value, and it follows the registers with no extra delay. A load strobe zeroes one slot's history when a fresh page is placed in that slot. All history registers are brought out on one flat bus so that a consumer can read the full ranking. The tick source, page-table walking and backing-store traffic live outside the block.

Top module: `page_age_selector`

## Requirements
- R1: An active-low reset clears every history register and every referenced flag, so that after reset every slot reads 0 and `victim_idx` is 0.
- R2: An access pulse on a slot sets that slot's referenced flag, and the flag stays set until a tick or a load. A clock edge that has no tick and no load on a slot leaves that slot's history register unchanged.
- R3: On a tick edge, each slot's history register takes the value (old value shifted right by one) with the referenced flag placed in bit AGE_W-1. For example, a slot referenced only in the first interval reads 8'h80 after the first tick.
- R4: A tick clears the referenced flag. A slot that is referenced only once therefore reads 8'h40 after the second tick and 8'h20 after the third.
- R5: An access pulse in the same cycle as a tick is counted in that tick's shift: bit AGE_W-1 becomes 1. The flag is clear afterwards, so the next tick shifts in 0.
- R6: `victim_idx` is the index of a slot whose history value is the smallest of all slots. It reflects the register values that are current after each edge, with no added cycle.
- R7: When several slots share the smallest value, `victim_idx` names the lowest index among them.
- R8: When `load_en` is high and `load_idx` names a slot, that slot's history register and referenced flag become 0 on that edge. This takes priority over a tick or an access to the same slot. Other slots behave as if no load had been given.
- R9: A load whose `load_idx` is PAGES or greater changes nothing.
- R10: Slot i occupies bits [i*AGE_W +: AGE_W] of `age_flat`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sampling tick, one cycle wide |
| access | input | PAGES | Per-slot access pulses |
| load_en | input | 1 | Zero the history of the slot named by load_idx |
| load_idx | input | IDX_W | Slot to be loaded |
| victim_idx | output | IDX_W | Slot with the smallest history (lowest index on a tie) |
| age_flat | output | PAGES*AGE_W | All history registers, slot i at [i*AGE_W +: AGE_W] |

## Verification
An access, tick or load given before a rising edge is visible in `age_flat` once that edge has passed. `victim_idx` is valid in the same cycle, because it is combinational from the registers. The bench changes inputs on falling edges and moves its reference model forward one step at each rising edge. It compares every history value and the victim at the following falling edge, which is exactly one edge after the stimulus. A referenced flag is never read directly: its effect is observed through the top bit that the next tick shifts in.

// File: rtl/age_pkg.sv
package age_pkg;

  localparam int DEF_PAGES = 6;
  localparam int DEF_AGE_W = 8;

  // what a slot does at the coming edge, highest priority first in encoding order of use
  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,
    SLOT_SHIFT = 2'd1,
    SLOT_LOAD  = 2'd2
  } slot_act_e;

endpackage

// File: rtl/age_load_decode.sv
module age_load_decode #(
  parameter int PAGES = age_pkg::DEF_PAGES,
  parameter int IDX_W = 3
) (
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_idx,
  output logic [PAGES-1:0] load_hit
);

  // out-of-range indices match no slot (R9)
  for (genvar g = 0; g < PAGES; g++) begin : g_hit
    assign load_hit[g] = load_en && (load_idx == IDX_W'(g));
  end

endmodule

// File: rtl/age_slot.sv
module age_slot
  import age_pkg::*;
#(
  parameter int AGE_W = age_pkg::DEF_AGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             acc,
  input  logic             load,
  output logic [AGE_W-1:0] age_o
);

  logic [AGE_W-1:0] age_q;
  logic             ref_q;
  slot_act_e        act;
  logic             ref_now;

  // fold a same-cycle access into the sample taken by a tick
  assign ref_now = ref_q | acc;

  function automatic logic [AGE_W-1:0] age_step(input logic [AGE_W-1:0] cur,
                                                input logic newest);
    return {newest, cur[AGE_W-1:1]};
  endfunction

  always_comb begin
    if (load)      act = SLOT_LOAD;
    else if (tick) act = SLOT_SHIFT;
    else           act = SLOT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      ref_q <= 1'b0;
    end else begin
      unique case (act)
        SLOT_LOAD: begin
          age_q <= '0;
          ref_q <= 1'b0;
        end
        SLOT_SHIFT: begin
          age_q <= age_step(age_q, ref_now);
          ref_q <= 1'b0;
        end
        default: begin
          ref_q <= ref_now;
        end
      endcase
    end
  end

  assign age_o = age_q;

  // R3: the lower bits after a shift are the old upper bits
  a_r3_shift_body: assert property (@(posedge clk) disable iff (!rst_n)
    (act == SLOT_SHIFT) |=> (age_q[AGE_W-2:0] == $past(age_q[AGE_W-1:1])));

  // R4: the flag is gone after a tick, so a tick with no new access enters 0
  a_r4_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (act == SLOT_SHIFT) |=> !ref_q);

  // R5: an access on the tick cycle lands in the top bit
  a_r5_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (act == SLOT_SHIFT && acc) |=> age_q[AGE_W-1]);

  // R2: no tick and no load keeps the history
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act == SLOT_HOLD) |=> $stable(age_q));

  // R2: the flag is sticky between ticks
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (act == SLOT_HOLD && acc) |=> ref_q);

  // R8: a load empties the slot whatever else happens
  a_r8_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (age_q == '0 && !ref_q));

endmodule

// File: rtl/age_argmin.sv
module age_argmin #(
  parameter int PAGES = age_pkg::DEF_PAGES,
  parameter int AGE_W = age_pkg::DEF_AGE_W,
  parameter int IDX_W = 3
) (
  input  logic [PAGES*AGE_W-1:0] ages,
  output logic [IDX_W-1:0]       min_idx,
  output logic [AGE_W-1:0]       min_val
);

  logic [AGE_W-1:0] run_val [PAGES];
  logic [IDX_W-1:0] run_idx [PAGES];

  // strict less-than: an equal later slot never displaces an earlier one (R7)
  function automatic logic beats(input logic [AGE_W-1:0] cand,
                                 input logic [AGE_W-1:0] best);
    return cand < best;
  endfunction

  assign run_val[0] = ages[0 +: AGE_W];
  assign run_idx[0] = '0;

  for (genvar g = 1; g < PAGES; g++) begin : g_chain
    logic take;
    assign take       = beats(ages[g*AGE_W +: AGE_W], run_val[g-1]);
    assign run_val[g] = take ? ages[g*AGE_W +: AGE_W] : run_val[g-1];
    assign run_idx[g] = take ? IDX_W'(g) : run_idx[g-1];
  end

  assign min_idx = run_idx[PAGES-1];
  assign min_val = run_val[PAGES-1];

endmodule

// File: rtl/page_age_selector.sv
module page_age_selector
  import age_pkg::*;
#(
  parameter int PAGES = age_pkg::DEF_PAGES,
  parameter int AGE_W = age_pkg::DEF_AGE_W,
  localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [PAGES-1:0]       access,
  input  logic                   load_en,
  input  logic [IDX_W-1:0]       load_idx,
  output logic [IDX_W-1:0]       victim_idx,
  output logic [PAGES*AGE_W-1:0] age_flat
);

  logic [PAGES-1:0] load_hit;
  logic [AGE_W-1:0] victim_age;

  age_load_decode #(.PAGES(PAGES), .IDX_W(IDX_W)) u_dec (
    .load_en  (load_en),
    .load_idx (load_idx),
    .load_hit (load_hit)
  );

  for (genvar g = 0; g < PAGES; g++) begin : g_slot
    age_slot #(.AGE_W(AGE_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .acc   (access[g]),
      .load  (load_hit[g]),
      .age_o (age_flat[g*AGE_W +: AGE_W])       // R10 layout
    );
  end

  age_argmin #(.PAGES(PAGES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_min (
    .ages    (age_flat),
    .min_idx (victim_idx),
    .min_val (victim_age)
  );

  // R9: at most one slot loads, none for an index beyond the pool
  a_r9_load_range: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && (int'(load_idx) >= PAGES)) |-> (load_hit == '0));

  a_r8_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_hit));

  // R1: everything reads zero one edge into reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (age_flat == '0));

  // R6 / R7: the victim really is the lowest-indexed minimum
  always_ff @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < PAGES; i++) begin
        a_r6_is_min: assert (!(age_flat[i*AGE_W +: AGE_W] < victim_age))
          else $error("victim value is not the minimum");
        if (i < int'(victim_idx)) begin
          a_r7_lowest_tie: assert (age_flat[i*AGE_W +: AGE_W] != victim_age)
            else $error("a lower slot ties the victim");
        end
      end
    end
  end

endmodule

// File: tb/page_age_selector_tb.sv
module page_age_selector_tb;

  localparam int N  = 6;
  localparam int W  = 8;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick = 1'b0;
  logic [N-1:0]    access = '0;
  logic            load_en = 1'b0;
  logic [IW-1:0]   load_idx = '0;
  logic [IW-1:0]   victim_idx;
  logic [N*W-1:0]  age_flat;

  int checks = 0;
  int failures = 0;

  int m_age [N];
  bit m_ref [N];

  page_age_selector #(.PAGES(N), .AGE_W(W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .access     (access),
    .load_en    (load_en),
    .load_idx   (load_idx),
    .victim_idx (victim_idx),
    .age_flat   (age_flat)
  );

  always #10 clk = ~clk;  // 50 MHz

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, got hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic int exp_victim();
    int best = 0;
    for (int i = 1; i < N; i++) if (m_age[i] < m_age[best]) best = i;
    return best;
  endfunction

  // reference step written from R2..R5, R8, R9
  task automatic model_step(bit t, logic [N-1:0] a, bit le, int li);
    for (int i = 0; i < N; i++) begin
      if (le && li == i) begin
        m_age[i] = 0;
        m_ref[i] = 0;
      end else if (t) begin
        m_age[i] = m_age[i] / 2 + ((m_ref[i] || a[i]) ? 128 : 0);
        m_ref[i] = 0;
      end else if (a[i]) begin
        m_ref[i] = 1;
      end
    end
  endtask

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < N; i++) check(req, int'(age_flat[i*W +: W]), m_age[i]);
    check(req, int'(victim_idx), exp_victim());
  endtask

  // one stimulus cycle: drive at falling edge, step model at rising, compare at next falling
  task automatic cyc(bit t, logic [N-1:0] a, bit le, int li, string req);
    @(negedge clk);
    tick = t; access = a; load_en = le; load_idx = IW'(li);
    @(posedge clk);
    model_step(t, a, le, li);
    @(negedge clk);
    tick = 0; access = '0; load_en = 0;
    check_all(req);
  endtask

  initial begin
    process::self().srandom(32'h5eed_a9e1);
    for (int i = 0; i < N; i++) begin m_age[i] = 0; m_ref[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");                              // reset state
    check("R1", int'(victim_idx), 0);

    cyc(0, 6'b000100, 0, 0, "R2");                // flag only, history still 0
    cyc(1, 6'b000000, 0, 0, "R3");                // slot 2 -> 8'h80
    check("R3", int'(age_flat[2*W +: W]), 8'h80);
    check("R10", int'(age_flat[23:16]), 8'h80);
    cyc(1, 6'b000000, 0, 0, "R4");                // slot 2 -> 8'h40
    check("R4", int'(age_flat[2*W +: W]), 8'h40);

    cyc(1, 6'b010000, 0, 0, "R5");                // access on tick -> 8'h80
    check("R5", int'(age_flat[4*W +: W]), 8'h80);
    cyc(1, 6'b000000, 0, 0, "R5");                // flag was clear -> 8'h40
    check("R5", int'(age_flat[4*W +: W]), 8'h40);

    cyc(1, 6'b000011, 0, 0, "R7");                // zeros left at 3 and 5
    check("R7", int'(victim_idx), 3);
    cyc(1, 6'b001000, 0, 0, "R7");                // only slot 5 still 0
    check("R6", int'(victim_idx), 5);

    cyc(0, 6'b000100, 0, 0, "R2");                // set slot 2 flag
    cyc(1, 6'b000100, 1, 2, "R8");                // load beats tick and access
    check("R8", int'(age_flat[2*W +: W]), 0);
    cyc(1, 6'b000000, 0, 0, "R8");                // flag was cleared by load
    check("R8", int'(age_flat[2*W +: W]), 0);

    cyc(0, 6'b000000, 1, 7, "R9");                // out of range load
    cyc(1, 6'b111111, 1, 6, "R9");                // out of range with tick: plain shift
    check("R9", int'(age_flat[0 +: W]), m_age[0]);

    for (int k = 0; k < 600; k++) begin
      bit t  = ($urandom % 4) == 0;
      logic [N-1:0] a = N'($urandom & $urandom);
      bit le = ($urandom % 8) == 0;
      int li = int'($urandom % 8);
      cyc(t, a, le, li, "R6");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule